// File: doc/BRIEF.md
# Sv32 Page-Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address using the two-level Sv32 page-table format. A request carries the virtual address, an access kind (fetch, load or store) and the privilege context. The walker then reads page-table entries one at a time through a simple read port. When it finds a leaf, it applies the full set of permission rules, sets the accessed bit and, for stores, the dirty bit. If the entry changed, it writes the entry back, and only then does it report the result.

The walker is meant to sit behind a translation cache. A miss starts one walk. The walk ends with a single-cycle `done` pulse that presents either a fault or a physical address together with read, write and execute permissions. Translation can be switched off (bare mode). It is also skipped when the effective privilege is machine mode. In both cases the address passes through with every permission granted and no memory traffic.

Top module: `sv32_walker`

## Requirements
- R1: When `xlate_en` is 0, or the effective privilege is machine (3), the result is the zero-extended virtual address with `perm_r`, `perm_w` and `perm_x` all 1, `fault` 0, and no memory read.
- R2: For loads and stores (kind 1, 2) issued at privilege 3 with `data_priv_override` set, the effective privilege is `data_priv`. Fetches (kind 0) always use `req_priv`. Privilege encoding: 0 user, 1 supervisor, 3 machine.
- R3: The first entry is read at `root_ppn`×4096 + `req_vaddr[31:22]`×4. An entry with V=1 and R=W=X=0 is a pointer: the next read is at `pte[31:10]`×4096 + `req_vaddr[21:12]`×4. Entry bit positions: V0 R1 W2 X3 U4 A6 D7, page number in [31:10].
- R4: A leaf with U=1 faults for a supervisor access unless `user_access_ok` is 1. A leaf with U=0 faults for any access that is not supervisor.
- R5: A leaf with V=0, or with W=1 and R=0, faults. A pointer found at the last level faults.
- R6: A fetch needs X. A load needs R, or X when `exec_readable` is 1. A store needs both R and W. A missing permission faults.
- R7: On a successful leaf, the entry with A set (and D set for a store) is written back to the address it was read from, before `done`, only if it differs from the entry read. No write happens on a fault.
- R8: The physical address is {entry page number, `req_vaddr[11:0]`}. For a leaf found at the first level, `req_vaddr[21:12]` is ORed into the low ten bits of the page number.
- R9: `perm_r` equals R and `perm_x` equals X. `perm_w` is 1 only when W=1 and either the access is a store or D was already 1.
- R10: A read request is a one-cycle pulse on `mem_rd_req`. No new request is issued until `mem_rd_valid` returns the entry. `req_valid` is ignored while a walk is in progress.
- R11: `done` is a one-cycle pulse. With `fault` 1, `paddr` and all permissions are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (sampled when idle) |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege |
| data_priv_override | input | 1 | Data accesses in machine mode use `data_priv` |
| data_priv | input | 2 | Privilege used for overridden data accesses |
| user_access_ok | input | 1 | Supervisor may touch user pages |
| exec_readable | input | 1 | Loads may read execute-only pages |
| xlate_en | input | 1 | 1 translate, 0 bare pass-through |
| root_ppn | input | 22 | Page number of the root table |
| mem_rd_req | output | 1 | Entry read request pulse |
| mem_addr | output | 34 | Entry address for read and write |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry read from memory |
| mem_wr_req | output | 1 | Entry write-back strobe |
| mem_wr_data | output | 32 | Updated entry |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk failed |
| paddr | output | 34 | Physical address |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |

## Verification
The assertions watch the port protocol on every cycle. They check the single-cycle `done` and read pulses, that read and write never overlap, and that every write-back follows a read of the same address, carries A, differs from the entry read and is followed by completion. They also check that a fault comes out with a zeroed result and that write permission never appears without read permission. The privilege, user-page, execute-readable and dirty-bit rules, the superpage merge, and the ignoring of a request during a walk depend on table contents. Only the bench scenarios can show those, by comparing each result and the memory image against a bench reference walk.

// File: rtl/sv32_walk_pkg.sv
package sv32_walk_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2
   } acc_e;

   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   localparam int BIT_V   = 0;
   localparam int BIT_R   = 1;
   localparam int BIT_W   = 2;
   localparam int BIT_X   = 3;
   localparam int BIT_U   = 4;
   localparam int BIT_A   = 6;
   localparam int BIT_D   = 7;
   localparam int PPN_LSB = 10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_WAIT,
      ST_WB,
      ST_FIN
   } walk_state_e;
endpackage

// File: rtl/sv32_walk_addr.sv
module sv32_walk_addr #(
   parameter int OFF_W  = 12,
   parameter int IDX_W  = 10,
   parameter int LEVELS = 2,
   parameter int PPN_W  = 22,
   parameter int PTE_W  = 32,
   parameter int PA_W   = PPN_W + OFF_W,
   parameter int VPN_W  = LEVELS * IDX_W,
   parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [LVL_W-1:0] lvl,
   input  logic [PPN_W-1:0] base_ppn,
   input  logic [PPN_W-1:0] leaf_ppn,
   output logic [PA_W-1:0]  pte_addr,
   output logic [PPN_W-1:0] leaf_ppn_merged
);
   localparam int PTE_BYTES = PTE_W / 8;
   localparam int SZ_SHIFT  = $clog2(PTE_BYTES);

   logic [IDX_W-1:0] idx_arr [LEVELS];
   logic [PPN_W-1:0] mrg_arr [LEVELS];

   for (genvar l = 0; l < LEVELS; l++) begin : g_level
      localparam logic [PPN_W-1:0] LOW_MASK = (PPN_W'(1) << (l * IDX_W)) - PPN_W'(1);
      assign idx_arr[l] = vpn[l*IDX_W +: IDX_W];
      assign mrg_arr[l] = leaf_ppn | (PPN_W'(vpn) & LOW_MASK);
   end

   assign pte_addr        = {base_ppn, OFF_W'(0)} + (PA_W'(idx_arr[lvl]) << SZ_SHIFT);
   assign leaf_ppn_merged = mrg_arr[lvl];
endmodule

// File: rtl/sv32_pte_judge.sv
module sv32_pte_judge
   import sv32_walk_pkg::*;
#(
   parameter int PTE_W = 32
) (
   input  logic [PTE_W-1:0] pte,
   input  acc_e             kind,
   input  logic             eff_sup,
   input  logic             user_ok,
   input  logic             exec_rd,
   input  logic             last_lvl,
   output logic             is_ptr,
   output logic             bad,
   output logic             need_wb,
   output logic [PTE_W-1:0] new_pte,
   output logic             pr,
   output logic             pw,
   output logic             px
);
   logic v, r, w, x, u, d, is_store;
   logic user_bad, shape_bad, acc_bad;

   assign v        = pte[BIT_V];
   assign r        = pte[BIT_R];
   assign w        = pte[BIT_W];
   assign x        = pte[BIT_X];
   assign u        = pte[BIT_U];
   assign d        = pte[BIT_D];
   assign is_store = (kind == ACC_STORE);

   assign is_ptr    = v && !r && !w && !x;
   assign user_bad  = u ? (eff_sup && !user_ok) : !eff_sup;
   assign shape_bad = !v || (w && !r);

   always_comb begin
      unique case (kind)
         ACC_FETCH: acc_bad = !x;
         ACC_STORE: acc_bad = !(r && w);
         default:   acc_bad = !(r || (exec_rd && x));
      endcase
   end

   assign bad     = is_ptr ? last_lvl : (user_bad || shape_bad || acc_bad);
   assign new_pte = pte | (PTE_W'(1) << BIT_A) | (is_store ? (PTE_W'(1) << BIT_D) : '0);
   assign need_wb = (new_pte != pte);
   assign pr      = r;
   assign px      = x;
   assign pw      = w && (is_store || d);
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker
   import sv32_walk_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int OFF_W  = 12,
   parameter int IDX_W  = 10,
   parameter int LEVELS = 2,
   parameter int PPN_W  = 22,
   parameter int PTE_W  = 32,
   parameter int PA_W   = 34
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_kind,
   input  logic [1:0]       req_priv,
   input  logic             data_priv_override,
   input  logic [1:0]       data_priv,
   input  logic             user_access_ok,
   input  logic             exec_readable,
   input  logic             xlate_en,
   input  logic [PPN_W-1:0] root_ppn,
   output logic             mem_rd_req,
   output logic [PA_W-1:0]  mem_addr,
   input  logic             mem_rd_valid,
   input  logic [PTE_W-1:0] mem_rd_data,
   output logic             mem_wr_req,
   output logic [PTE_W-1:0] mem_wr_data,
   output logic             done,
   output logic             fault,
   output logic [PA_W-1:0]  paddr,
   output logic             perm_r,
   output logic             perm_w,
   output logic             perm_x
);
   localparam int VPN_W = VA_W - OFF_W;
   localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

   if (VA_W != OFF_W + LEVELS * IDX_W) begin : g_chk_va
      $error("virtual width must equal offset plus all index fields");
   end
   if (PA_W != PPN_W + OFF_W) begin : g_chk_pa
      $error("physical width must equal page number plus offset");
   end
   if (PTE_W != PPN_W + PPN_LSB) begin : g_chk_pte
      $error("entry width must hold the page number above the flag bits");
   end
   if (LEVELS < 2 || PA_W < VA_W) begin : g_chk_lvl
      $error("walker needs two or more levels and a physical space no narrower than virtual");
   end

   walk_state_e      state_q;
   logic [VA_W-1:0]  va_q;
   acc_e             kind_q;
   logic             sup_q, uok_q, xrd_q;
   logic [LVL_W-1:0] lvl_q;
   logic [PPN_W-1:0] base_q;
   logic [PTE_W-1:0] wb_q;
   logic             fault_q, r_q, w_q, x_q;
   logic [PA_W-1:0]  pa_q;

   logic [1:0]       eff_mode;
   logic             pass_thru;
   logic [PA_W-1:0]  ent_addr;
   logic [PPN_W-1:0] merged_ppn;
   logic             jd_ptr, jd_bad, jd_wb, jd_r, jd_w, jd_x;
   logic [PTE_W-1:0] jd_new;

   assign eff_mode  = (req_priv == PRIV_M && req_kind != ACC_FETCH && data_priv_override)
                      ? data_priv : req_priv;
   assign pass_thru = !xlate_en || (eff_mode == PRIV_M);

   sv32_walk_addr #(
      .OFF_W (OFF_W),
      .IDX_W (IDX_W),
      .LEVELS(LEVELS),
      .PPN_W (PPN_W),
      .PTE_W (PTE_W),
      .PA_W  (PA_W),
      .VPN_W (VPN_W),
      .LVL_W (LVL_W)
   ) u_addr (
      .vpn            (va_q[VA_W-1:OFF_W]),
      .lvl            (lvl_q),
      .base_ppn       (base_q),
      .leaf_ppn       (mem_rd_data[PTE_W-1:PPN_LSB]),
      .pte_addr       (ent_addr),
      .leaf_ppn_merged(merged_ppn)
   );

   sv32_pte_judge #(
      .PTE_W(PTE_W)
   ) u_judge (
      .pte     (mem_rd_data),
      .kind    (kind_q),
      .eff_sup (sup_q),
      .user_ok (uok_q),
      .exec_rd (xrd_q),
      .last_lvl(lvl_q == '0),
      .is_ptr  (jd_ptr),
      .bad     (jd_bad),
      .need_wb (jd_wb),
      .new_pte (jd_new),
      .pr      (jd_r),
      .pw      (jd_w),
      .px      (jd_x)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         va_q    <= '0;
         kind_q  <= ACC_FETCH;
         sup_q   <= 1'b0;
         uok_q   <= 1'b0;
         xrd_q   <= 1'b0;
         lvl_q   <= '0;
         base_q  <= '0;
         wb_q    <= '0;
         fault_q <= 1'b0;
         pa_q    <= '0;
         r_q     <= 1'b0;
         w_q     <= 1'b0;
         x_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr;
                  kind_q <= acc_e'(req_kind);
                  sup_q  <= (eff_mode == PRIV_S);
                  uok_q  <= user_access_ok;
                  xrd_q  <= exec_readable;
                  lvl_q  <= TOP_LVL;
                  base_q <= root_ppn;
                  if (pass_thru) begin
                     fault_q <= 1'b0;
                     pa_q    <= PA_W'(req_vaddr);
                     r_q     <= 1'b1;
                     w_q     <= 1'b1;
                     x_q     <= 1'b1;
                     state_q <= ST_FIN;
                  end else begin
                     state_q <= ST_REQ;
                  end
               end
            end
            ST_REQ: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rd_valid) begin
                  if (jd_bad) begin
                     fault_q <= 1'b1;
                     pa_q    <= '0;
                     r_q     <= 1'b0;
                     w_q     <= 1'b0;
                     x_q     <= 1'b0;
                     state_q <= ST_FIN;
                  end else if (jd_ptr) begin
                     base_q  <= mem_rd_data[PTE_W-1:PPN_LSB];
                     lvl_q   <= lvl_q - LVL_W'(1);
                     state_q <= ST_REQ;
                  end else begin
                     fault_q <= 1'b0;
                     pa_q    <= {merged_ppn, va_q[OFF_W-1:0]};
                     r_q     <= jd_r;
                     w_q     <= jd_w;
                     x_q     <= jd_x;
                     wb_q    <= jd_new;
                     state_q <= jd_wb ? ST_WB : ST_FIN;
                  end
               end
            end
            ST_WB:   state_q <= ST_FIN;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd_req  = (state_q == ST_REQ);
   assign mem_wr_req  = (state_q == ST_WB);
   assign mem_addr    = ent_addr;
   assign mem_wr_data = wb_q;
   assign done        = (state_q == ST_FIN);
   assign fault       = fault_q;
   assign paddr       = pa_q;
   assign perm_r      = r_q;
   assign perm_w      = w_q;
   assign perm_x      = x_q;
endmodule

// File: rtl/sv32_walker_chk.sv
module sv32_walker_chk
   import sv32_walk_pkg::*;
#(
   parameter int PA_W  = 34,
   parameter int PTE_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic             fault,
   input logic [PA_W-1:0]  paddr,
   input logic             perm_r,
   input logic             perm_w,
   input logic             perm_x,
   input logic             mem_rd_req,
   input logic             mem_rd_valid,
   input logic [PTE_W-1:0] mem_rd_data,
   input logic             mem_wr_req,
   input logic [PTE_W-1:0] mem_wr_data,
   input logic [PA_W-1:0]  mem_addr
);
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_fault_zeroed_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (!perm_r && !perm_w && !perm_x && paddr == '0));

   assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);

   assert_port_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req));

   assert_wb_sets_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> mem_wr_data[BIT_A]);

   assert_wb_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> ($past(mem_rd_valid) && $stable(mem_addr)
                      && mem_wr_data != $past(mem_rd_data)));

   assert_wb_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |=> done);

   assert_w_needs_r_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && perm_w) |-> perm_r);
endmodule

bind sv32_walker sv32_walker_chk #(
   .PA_W (PA_W),
   .PTE_W(PTE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .done        (done),
   .fault       (fault),
   .paddr       (paddr),
   .perm_r      (perm_r),
   .perm_w      (perm_w),
   .perm_x      (perm_x),
   .mem_rd_req  (mem_rd_req),
   .mem_rd_valid(mem_rd_valid),
   .mem_rd_data (mem_rd_data),
   .mem_wr_req  (mem_wr_req),
   .mem_wr_data (mem_wr_data),
   .mem_addr    (mem_addr)
);

// File: tb/sv32_walker_tb.sv
`timescale 1ns/1ps
module sv32_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic [1:0]  req_priv = '0;
   logic        dpo = 1'b0;
   logic [1:0]  dpriv = '0;
   logic        uok = 1'b0;
   logic        xrd = 1'b0;
   logic        xen = 1'b0;
   logic [21:0] root = '0;
   logic        mem_rd_req, mem_wr_req, done, fault, perm_r, perm_w, perm_x;
   logic [33:0] mem_addr, paddr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic [31:0] mem_wr_data;

   int checks = 0;
   int fails = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;

   logic [31:0] pmem [logic [33:0]];

   typedef struct {
      bit          flt;
      logic [33:0] pa;
      bit          r, w, x;
      bit          wb;
      logic [33:0] wa;
      logic [31:0] wv;
   } exp_t;

   always #10 clk = ~clk;

   sv32_walker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .req_priv(req_priv), .data_priv_override(dpo),
      .data_priv(dpriv), .user_access_ok(uok), .exec_readable(xrd),
      .xlate_en(xen), .root_ppn(root), .mem_rd_req(mem_rd_req),
      .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_req(mem_wr_req), .mem_wr_data(mem_wr_data), .done(done),
      .fault(fault), .paddr(paddr), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
   );

   function automatic logic [31:0] peek(input logic [33:0] a);
      return pmem.exists(a) ? pmem[a] : 32'h0;
   endfunction

   // memory model: answers a read 1..3 cycles after the request, stores writes
   logic        pend = 1'b0;
   int          lat = 0;
   logic [33:0] pend_a = '0;
   always @(negedge clk) begin
      if (mem_rd_valid) mem_rd_valid = 1'b0;
      if (pend) begin
         if (lat == 0) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = peek(pend_a);
            pend = 1'b0;
         end else lat--;
      end
      if (rst_n && mem_rd_req) begin
         pend = 1'b1;
         lat = $urandom_range(0, 2);
         pend_a = mem_addr;
         rd_cnt++;
      end
      if (rst_n && mem_wr_req) begin
         pmem[mem_addr] = mem_wr_data;
         wr_cnt++;
      end
   end

   // independent reference walk computed from the requirements
   function automatic exp_t ref_walk(input logic [31:0] va, input logic [1:0] kind,
                                     input logic [1:0] pv, input bit ov, input logic [1:0] opv,
                                     input bit uo, input bit xr, input bit en,
                                     input logic [21:0] rt);
      exp_t e;
      logic [1:0] em;
      logic [21:0] base;
      e = '{flt: 0, pa: {2'b00, va}, r: 1, w: 1, x: 1, wb: 0, wa: '0, wv: '0};
      em = (pv == 2'd3 && kind != 2'd0 && ov) ? opv : pv;
      if (!en || em == 2'd3) return e;
      base = rt;
      for (int lv = 1; lv >= 0; lv--) begin
         logic [33:0] a;
         logic [31:0] p, q;
         logic [9:0]  ix;
         bit v, r, w, x, u, d, bad;
         ix = (lv == 1) ? va[31:22] : va[21:12];
         a = {base, 12'h000} + {22'h0, ix, 2'b00};
         p = peek(a);
         v = p[0]; r = p[1]; w = p[2]; x = p[3]; u = p[4]; d = p[7];
         if (v && !r && !w && !x) begin
            if (lv == 0) break;
            base = p[31:10];
            continue;
         end
         bad = !v || (w && !r);
         if (u && em == 2'd1 && !uo) bad = 1;
         if (!u && em != 2'd1) bad = 1;
         if (kind == 2'd0 && !x) bad = 1;
         if (kind == 2'd2 && !(r && w)) bad = 1;
         if (kind != 2'd0 && kind != 2'd2 && !(r || (xr && x))) bad = 1;
         if (bad) break;
         q = p | 32'h40 | ((kind == 2'd2) ? 32'h80 : 32'h0);
         e.flt = 0;
         e.r = r; e.x = x; e.w = w && (kind == 2'd2 || d);
         e.pa = (lv == 1) ? {p[31:20], p[19:10] | va[21:12], va[11:0]} : {p[31:10], va[11:0]};
         e.wb = (q != p); e.wa = a; e.wv = q;
         return e;
      end
      e = '{flt: 1, pa: '0, r: 0, w: 0, x: 0, wb: 0, wa: '0, wv: '0};
      return e;
   endfunction

   task automatic check(input string tag, input bit ok, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic run_vec(input string tag, input logic [31:0] va, input logic [1:0] kind,
                          input logic [1:0] pv, input bit ov, input logic [1:0] opv,
                          input bit uo, input bit xr, input bit en, input logic [21:0] rt,
                          input bit bump);
      exp_t e;
      int rd0, wr0;
      bit extra;
      e = ref_walk(va, kind, pv, ov, opv, uo, xr, en, rt);
      rd0 = rd_cnt; wr0 = wr_cnt;
      @(negedge clk);
      req_vaddr = va; req_kind = kind; req_priv = pv; dpo = ov; dpriv = opv;
      uok = uo; xrd = xr; xen = en; root = rt; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (bump) begin
         @(negedge clk);
         req_vaddr = ~va; xen = 1'b0; req_priv = 2'd3; req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0; req_vaddr = va; xen = en; req_priv = pv;
      end
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      check(tag, done === 1'b1, "done seen", {63'h0, done}, 64'h1);
      check(tag, fault === e.flt, "fault", {63'h0, fault}, {63'h0, e.flt});
      check(tag, paddr === e.pa, "paddr", {30'h0, paddr}, {30'h0, e.pa});
      check(tag, {perm_r, perm_w, perm_x} === {e.r, e.w, e.x}, "perm rwx",
            {61'h0, perm_r, perm_w, perm_x}, {61'h0, e.r, e.w, e.x});
      if (e.wb)
         check(tag, (wr_cnt == wr0 + 1) && peek(e.wa) === e.wv, "written entry",
               {32'h0, peek(e.wa)}, {32'h0, e.wv});
      else
         check(tag, wr_cnt == wr0, "write count", 64'(wr_cnt - wr0), 64'h0);
      if (!en || e.pa === {2'b00, va} && e.r && e.w && e.x && !e.flt && rd_cnt == rd0)
         check(tag, rd_cnt == rd0 || en, "reads in pass-through", 64'(rd_cnt - rd0), 64'h0);
      if (bump) begin
         extra = 0;
         repeat (8) begin
            @(negedge clk);
            if (done) extra = 1;
         end
         check("R10", !extra, "second done after ignored request", {63'h0, extra}, 64'h0);
      end
   endtask

   localparam logic [21:0] RT  = 22'h00100;
   localparam logic [33:0] L0E = {22'h00200, 12'h080};
   localparam logic [31:0] VA0 = {10'h004, 10'h020, 12'h010};

   task automatic set_leaf(input logic [7:0] fl);
      pmem[L0E] = {22'h0ABCD, 2'b00, fl};
   endtask

   initial begin
      void'($urandom(32'h5eed1234));
      repeat (3) @(negedge clk);
      check("R11", done === 1'b0 && fault === 1'b0, "reset done/fault", {62'h0, done, fault}, 64'h0);
      check("R10", mem_rd_req === 1'b0 && mem_wr_req === 1'b0, "reset memory strobes",
            {62'h0, mem_rd_req, mem_wr_req}, 64'h0);
      rst_n = 1'b1;

      // tables for directed cases
      pmem[{RT, 12'h000} + 34'd12] = {22'h12C00, 10'h0C7};          // first-level leaf
      pmem[{RT, 12'h000} + 34'd16] = {22'h00200, 10'h001};          // pointer
      set_leaf(8'hC7);

      run_vec("R1", 32'hDEADB123, 2'd1, 2'd1, 0, 2'd0, 0, 0, 0, RT, 0);
      check("R1", paddr === 34'h0DEADB123, "bare paddr", {30'h0, paddr}, 64'h0DEADB123);
      run_vec("R1", VA0, 2'd2, 2'd3, 0, 2'd0, 0, 0, 1, RT, 0);
      run_vec("R2", VA0, 2'd1, 2'd3, 1, 2'd1, 0, 0, 1, RT, 0);
      run_vec("R2", VA0, 2'd0, 2'd3, 1, 2'd1, 0, 0, 1, RT, 0);
      run_vec("R8", {10'h003, 10'h155, 12'hABC}, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, RT, 0);
      check("R8", paddr === 34'h12D55ABC, "superpage merge", {30'h0, paddr}, 64'h12D55ABC);
      run_vec("R3", VA0, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, RT, 0);
      check("R3", paddr === {22'h0ABCD, 12'h010}, "two-level paddr", {30'h0, paddr},
            {30'h0, 22'h0ABCD, 12'h010});

      set_leaf(8'h07);
      run_vec("R7", VA0, 2'd2, 2'd1, 0, 2'd0, 0, 0, 1, RT, 0);
      check("R7", pmem[L0E] === {22'h0ABCD, 10'h0C7}, "store sets A and D",
            {32'h0, pmem[L0E]}, {32'h0, 22'h0ABCD, 10'h0C7});
      set_leaf(8'h07);
      run_vec("R9", VA0, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, RT, 0);
      check("R9", perm_w === 1'b0, "clean page load hides write", {63'h0, perm_w}, 64'h0);
      set_leaf(8'hC7);
      run_vec("R9", VA0, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, RT, 0);

      set_leaf(8'h01); run_vec("R5", VA0, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, RT, 0);
      set_leaf(8'h45); run_vec("R5", VA0, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, RT, 0);
      set_leaf(8'h46); run_vec("R5", VA0, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, RT, 0);

      set_leaf(8'h53);
      run_vec("R4", VA0, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, RT, 0);
      run_vec("R4", VA0, 2'd1, 2'd1, 0, 2'd0, 1, 0, 1, RT, 0);
      run_vec("R4", VA0, 2'd1, 2'd0, 0, 2'd0, 0, 0, 1, RT, 0);
      set_leaf(8'h43);
      run_vec("R4", VA0, 2'd1, 2'd0, 0, 2'd0, 0, 0, 1, RT, 0);

      set_leaf(8'h49);
      run_vec("R6", VA0, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, RT, 0);
      run_vec("R6", VA0, 2'd1, 2'd1, 0, 2'd0, 0, 1, 1, RT, 0);
      run_vec("R6", VA0, 2'd0, 2'd1, 0, 2'd0, 0, 0, 1, RT, 0);
      run_vec("R6", VA0, 2'd2, 2'd1, 0, 2'd0, 0, 0, 1, RT, 0);

      set_leaf(8'hC7);
      run_vec("R10", VA0, 2'd1, 2'd1, 0, 2'd0, 0, 0, 1, RT, 1);

      // constrained random walks
      for (int n = 0; n < 400; n++) begin
         logic [31:0] va;
         logic [21:0] rt, l0p;
         logic [1:0]  pv, opv;
         logic [7:0]  fl;
         va  = $urandom;
         rt  = 22'($urandom);
         l0p = rt + 22'd1 + 22'($urandom_range(0, 999));
         fl  = 8'($urandom);
         if ($urandom_range(0, 9) < 8) fl[0] = 1'b1;
         if ($urandom_range(0, 9) < 6) begin
            pmem[{rt, 12'h000} + {22'h0, va[31:22], 2'b00}] = {l0p, 10'h001};
            pmem[{l0p, 12'h000} + {22'h0, va[21:12], 2'b00}] = {22'($urandom), 2'($urandom), fl};
         end else begin
            pmem[{rt, 12'h000} + {22'h0, va[31:22], 2'b00}] = {22'($urandom), 2'($urandom), fl};
         end
         case ($urandom_range(0, 2)) 0: pv = 2'd0; 1: pv = 2'd1; default: pv = 2'd3; endcase
         case ($urandom_range(0, 2)) 0: opv = 2'd0; 1: opv = 2'd1; default: opv = 2'd3; endcase
         run_vec("R6", va, 2'($urandom_range(0, 2)), pv, 1'($urandom), opv,
                 1'($urandom), 1'($urandom), ($urandom_range(0, 9) != 0), rt, 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule